// File: doc/BRIEF.md
# Global Event Multicast Mapper

This block takes global events, each tagged with a 16-bit event index, from a single ingress port. It uses that index to select one entry of a mapping table. It then re-emits the event on two egress ports, and each port carries its own index taken from the selected entry. Either copy can be switched off by storing the all-ones index 0xFFFF in its field. Software programs the table through a small register port with a region-select input, a byte address, 64-bit write data and 64-bit read data. The port answers only when the select input carries the block's region code.

The event path has one stage. A two-state controller runs it. In state EMPTY no event is held and the ingress port is ready. On an accepted ingress event the controller takes the transition ACCEPT into state FULL, and the table lookup is captured there. In FULL the enabled copies are offered on the egress ports. The controller takes RELEASE once every enabled port is ready at the same time. If a new event is accepted in that same cycle, the transition is RELEASE_ACCEPT and the controller stays in FULL. If no new event arrives, the transition is RELEASE_IDLE and the controller returns to EMPTY. When a copy is not ready, the controller takes HOLD and stays in FULL with its outputs frozen. An event whose copies are all disabled, or whose index lies outside the table, is released on the first FULL cycle without emitting anything.

Top module: `gev_fanout_mapper`

## Requirements
- R1: After reset, every entry reads back as 0x0000FFFF_0000FFFF, and no ingress event produces an egress event until its entry is written.
- R2: In an entry word, bits 15:0 hold the port-0 index and bits 47:32 hold the port-1 index. Bits 31:16 and 63:48 are dropped on write and read as zero.
- R3: A field equal to 0xFFFF suppresses that port's copy. Any other value is emitted unchanged on that port.
- R4: Entry j sits at byte address j*0x20. A read or write takes effect only when the select input equals 5 (REGION_ID); with any other select the table and the read data are left unchanged.
- R5: An ingress event whose index is at or above NUM_ENTRIES is consumed and emits nothing. A configuration write beyond the table is ignored, and a read beyond the table returns zero.
- R6: A held event is released only when every enabled egress port is ready in the same cycle. The ready of a disabled port has no effect. Ingress ready stays low while the held event waits.
- R7: Egress copies appear in the cycle after the ingress event is accepted. Events stream at one per cycle and leave in arrival order.
- R8: When a configuration write and a lookup of the same entry happen in the same cycle, the lookup sees the old contents. The new contents apply from the next cycle.
- R9: While an egress copy is valid but not taken, its index stays stable.
- R10: Read data updates one cycle after a selected read strobe and resets to zero. After reset both egress valids are low and ingress ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_sel | input | SEL_W | Region select; this block answers REGION_ID |
| cfg_addr | input | ADDR_W | Byte address within the region |
| cfg_wr | input | 1 | Write strobe |
| cfg_rd | input | 1 | Read strobe |
| cfg_wdata | input | 64 | Write data |
| cfg_rdata | output | 64 | Read data, registered |
| in_valid | input | 1 | Ingress event valid |
| in_ready | output | 1 | Ingress event ready |
| in_idx | input | 16 | Ingress event index |
| out0_valid | output | 1 | Egress port 0 valid |
| out0_ready | input | 1 | Egress port 0 ready |
| out0_idx | output | 16 | Egress port 0 index |
| out1_valid | output | 1 | Egress port 1 valid |
| out1_ready | input | 1 | Egress port 1 ready |
| out1_idx | output | 16 | Egress port 1 index |

## Verification
The hardest situation to reach from the ports is a configuration write and a lookup of the same entry landing on the same clock edge. The bench gets there by driving the write strobe and the ingress event together at one falling edge. It then checks that the released copies carry the old indices and that the next event to the same entry carries the new ones. A partial-ready stall is also hard to reach, because each copy waits for the other port. The bench holds one port's ready low for several cycles to create it and checks that the waiting index stays frozen until both readies are high.

// File: rtl/gevm_pkg.sv
package gevm_pkg;

    localparam int GEVM_IDX_W    = 16;
    localparam int GEVM_SLOT_LSB = 5;
    localparam logic [GEVM_IDX_W-1:0] GEVM_OFF = 16'hFFFF;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } gevm_state_e;

    typedef struct packed {
        logic [GEVM_IDX_W-1:0] idx1;
        logic [GEVM_IDX_W-1:0] idx0;
    } gevm_entry_t;

endpackage

// File: rtl/gevm_cfg_decode.sv
module gevm_cfg_decode #(
    parameter int NUM_ENTRIES = 512,
    parameter int ADDR_W      = 16,
    parameter int SEL_W       = 3,
    parameter int REGION_ID   = 5,
    parameter int ENT_W       = 9
) (
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [ADDR_W-1:0] cfg_addr,
    output logic              hit,
    output logic              in_range,
    output logic [ENT_W-1:0]  ent
);
    import gevm_pkg::*;

    logic [31:0] slot;

    always_comb begin
        hit      = (cfg_sel == SEL_W'(REGION_ID));
        slot     = 32'(cfg_addr) >> GEVM_SLOT_LSB;
        in_range = (slot < 32'(NUM_ENTRIES));
        ent      = slot[ENT_W-1:0];
    end

endmodule

// File: rtl/gevm_map_table.sv
module gevm_map_table #(
    parameter int NUM_ENTRIES = 512,
    parameter int ENT_W       = 9
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [ENT_W-1:0]            wr_ent,
    input  gevm_pkg::gevm_entry_t       wr_data,
    input  logic                        rd_en,
    input  logic                        rd_ok,
    input  logic [ENT_W-1:0]            rd_ent,
    output logic [63:0]                 rd_word,
    input  logic                        lk_en,
    input  logic                        lk_ok,
    input  logic [ENT_W-1:0]            lk_ent,
    output gevm_pkg::gevm_entry_t       lk_data
);
    import gevm_pkg::*;

    gevm_entry_t            mem [NUM_ENTRIES];
    logic [NUM_ENTRIES-1:0] written;

    // one "has been written" flag per entry stands in for a full reset of the array
    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                written[g] <= 1'b0;
            end else if (wr_en && (wr_ent == ENT_W'(g))) begin
                written[g] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_ent] <= wr_data;
        end
    end

    function automatic gevm_entry_t fetch(input logic [ENT_W-1:0] e);
        gevm_entry_t r;
        if (written[e]) begin
            r = mem[e];
        end else begin
            r.idx0 = GEVM_OFF;
            r.idx1 = GEVM_OFF;
        end
        return r;
    endfunction

    // lookup port: nonblocking update, so a same-edge write is not seen
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lk_data.idx0 <= GEVM_OFF;
            lk_data.idx1 <= GEVM_OFF;
        end else if (lk_en) begin
            if (lk_ok) begin
                lk_data <= fetch(lk_ent);
            end else begin
                lk_data.idx0 <= GEVM_OFF;
                lk_data.idx1 <= GEVM_OFF;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_word <= '0;
        end else if (rd_en) begin
            if (rd_ok) begin
                rd_word <= {16'h0, fetch(rd_ent).idx1, 16'h0, fetch(rd_ent).idx0};
            end else begin
                rd_word <= '0;
            end
        end
    end

    assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_word[63:48] == 16'h0) && (rd_word[31:16] == 16'h0))
        else $error("reserved read bits not zero");

    assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_word))
        else $error("read data moved without a read");

endmodule

// File: rtl/gevm_egress_ctrl.sv
module gevm_egress_ctrl (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    output logic                  in_ready,
    output logic                  accept,
    input  gevm_pkg::gevm_entry_t held,
    output logic                  out0_valid,
    input  logic                  out0_ready,
    output logic [15:0]           out0_idx,
    output logic                  out1_valid,
    input  logic                  out1_ready,
    output logic [15:0]           out1_idx
);
    import gevm_pkg::*;

    gevm_state_e st_q, st_d;
    logic        en0, en1, release_ev;

    always_comb begin
        en0        = (st_q == ST_FULL) && (held.idx0 != GEVM_OFF);
        en1        = (st_q == ST_FULL) && (held.idx1 != GEVM_OFF);
        release_ev = (st_q == ST_FULL) && (!en0 || out0_ready) && (!en1 || out1_ready);
        in_ready   = (st_q == ST_EMPTY) || release_ev;
        accept     = in_valid && in_ready;
    end

    // next-state selection: ACCEPT, HOLD, RELEASE_ACCEPT, RELEASE_IDLE
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_EMPTY: st_d = accept ? ST_FULL : ST_EMPTY;
            ST_FULL:  begin
                if (release_ev) begin
                    st_d = accept ? ST_FULL : ST_EMPTY;
                end else begin
                    st_d = ST_FULL;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_EMPTY;
        end else begin
            st_q <= st_d;
        end
    end

    // outputs: a copy is offered only when its partner can go in the same cycle
    always_comb begin
        out0_valid = en0 && (!en1 || out1_ready);
        out1_valid = en1 && (!en0 || out0_ready);
        out0_idx   = held.idx0;
        out1_idx   = held.idx1;
    end

    assert_copy0_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out0_valid |-> (out0_idx != 16'hFFFF))
        else $error("disabled copy emitted on port 0");

    assert_copy1_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out1_valid |-> (out1_idx != 16'hFFFF))
        else $error("disabled copy emitted on port 1");

    assert_pair_together_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out0_valid && out1_valid) |-> (out0_ready && out1_ready))
        else $error("copies split across cycles");

    assert_hold_idx0_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out0_valid && !out0_ready) |=> $stable(out0_idx))
        else $error("port 0 index moved while waiting");

    assert_hold_idx1_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out1_valid && !out1_ready) |=> $stable(out1_idx))
        else $error("port 1 index moved while waiting");

    assert_accept_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (st_q == ST_FULL))
        else $error("accepted event not held");

endmodule

// File: rtl/gev_fanout_mapper.sv
module gev_fanout_mapper #(
    parameter int NUM_ENTRIES = 512,
    parameter int ADDR_W      = 16,
    parameter int SEL_W       = 3,
    parameter int REGION_ID   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              cfg_wr,
    input  logic              cfg_rd,
    input  logic [63:0]       cfg_wdata,
    output logic [63:0]       cfg_rdata,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [15:0]       in_idx,
    output logic              out0_valid,
    input  logic              out0_ready,
    output logic [15:0]       out0_idx,
    output logic              out1_valid,
    input  logic              out1_ready,
    output logic [15:0]       out1_idx
);
    import gevm_pkg::*;

    localparam int ENT_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

    logic             cfg_hit, cfg_ok, accept, lk_ok;
    logic [ENT_W-1:0] cfg_ent, lk_ent;
    gevm_entry_t      wr_data, held;
    logic             unused_rsvd;

    gevm_cfg_decode #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .ADDR_W      (ADDR_W),
        .SEL_W       (SEL_W),
        .REGION_ID   (REGION_ID),
        .ENT_W       (ENT_W)
    ) u_decode (
        .cfg_sel  (cfg_sel),
        .cfg_addr (cfg_addr),
        .hit      (cfg_hit),
        .in_range (cfg_ok),
        .ent      (cfg_ent)
    );

    always_comb begin
        wr_data.idx0 = cfg_wdata[15:0];
        wr_data.idx1 = cfg_wdata[47:32];
        unused_rsvd  = ^{cfg_wdata[63:48], cfg_wdata[31:16]};
        lk_ent       = in_idx[ENT_W-1:0];
        lk_ok        = (32'(in_idx) < 32'(NUM_ENTRIES));
    end

    gevm_map_table #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .ENT_W       (ENT_W)
    ) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr && cfg_hit && cfg_ok),
        .wr_ent  (cfg_ent),
        .wr_data (wr_data),
        .rd_en   (cfg_rd && cfg_hit),
        .rd_ok   (cfg_ok),
        .rd_ent  (cfg_ent),
        .rd_word (cfg_rdata),
        .lk_en   (accept),
        .lk_ok   (lk_ok),
        .lk_ent  (lk_ent),
        .lk_data (held)
    );

    gevm_egress_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .accept     (accept),
        .held       (held),
        .out0_valid (out0_valid),
        .out0_ready (out0_ready),
        .out0_idx   (out0_idx),
        .out1_valid (out1_valid),
        .out1_ready (out1_ready),
        .out1_idx   (out1_idx)
    );

    assert_foreign_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_sel != SEL_W'(REGION_ID)) |=> $stable(cfg_rdata))
        else $error("read data changed on a foreign select");

endmodule

// File: tb/gev_fanout_mapper_bench.sv
module gev_fanout_mapper_bench;

    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [15:0] cfg_addr = '0;
    logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
    logic [63:0] cfg_wdata = '0;
    logic [63:0] cfg_rdata;
    logic        in_valid = 1'b0, in_ready;
    logic [15:0] in_idx = '0;
    logic        out0_valid, out1_valid;
    logic        out0_ready = 1'b1, out1_ready = 1'b1;
    logic [15:0] out0_idx, out1_idx;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    gev_fanout_mapper #(.NUM_ENTRIES(N)) u_gev_fanout_mapper (
        .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .cfg_addr(cfg_addr),
        .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .in_valid(in_valid), .in_ready(in_ready), .in_idx(in_idx),
        .out0_valid(out0_valid), .out0_ready(out0_ready), .out0_idx(out0_idx),
        .out1_valid(out1_valid), .out1_ready(out1_ready), .out1_idx(out1_idx)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] v0(input int j);
        return (j % 4 == 3) ? 16'hFFFF : 16'(16'h0100 + 3 * j);
    endfunction
    function automatic logic [15:0] v1(input int j);
        return (j % 5 == 4) ? 16'hFFFF : (16'hA500 ^ 16'(j));
    endfunction

    task automatic cfg_write(input logic [2:0] sel, input int j, input logic [63:0] d);
        @(negedge clk);
        cfg_sel = sel; cfg_addr = 16'(j * 32); cfg_wr = 1'b1; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic cfg_read(input logic [2:0] sel, input int j, input logic [63:0] exp, input string req);
        @(negedge clk);
        cfg_sel = sel; cfg_addr = 16'(j * 32); cfg_rd = 1'b1;
        @(negedge clk);
        cfg_rd = 1'b0;
        chk(req, cfg_rdata, exp);
    endtask

    // stream indices lo..hi back to back; programmed selects the expected table
    task automatic stream(input int lo, input int hi, input bit programmed, input string req);
        @(negedge clk);
        in_valid = 1'b1; in_idx = 16'(lo);
        for (int i = lo; i <= hi; i++) begin
            logic [15:0] e0, e1;
            @(negedge clk);
            e0 = (i < N && programmed) ? v0(i) : 16'hFFFF;
            e1 = (i < N && programmed) ? v1(i) : 16'hFFFF;
            chk({req, " valid0"}, 64'(out0_valid), 64'(e0 != 16'hFFFF));
            chk({req, " valid1"}, 64'(out1_valid), 64'(e1 != 16'hFFFF));
            if (e0 != 16'hFFFF) chk({req, " idx0"}, 64'(out0_idx), 64'(e0));
            if (e1 != 16'hFFFF) chk({req, " idx1"}, 64'(out1_idx), 64'(e1));
            chk({req, " streaming ready"}, 64'(in_ready), 64'(1));
            if (i < hi) in_idx = 16'(i + 1);
            else in_valid = 1'b0;
        end
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 out0_valid", 64'(out0_valid), 64'(0));
        chk("R10 out1_valid", 64'(out1_valid), 64'(0));
        chk("R10 in_ready", 64'(in_ready), 64'(1));
        chk("R10 rdata", cfg_rdata, 64'h0);

        // R1 reset contents, R5 out-of-range reads
        for (int j = 0; j < N; j++) cfg_read(3'd5, j, 64'h0000FFFF_0000FFFF, "R1 reset entry");
        cfg_read(3'd5, N, 64'h0, "R5 read beyond table");
        cfg_read(3'd5, N + 7, 64'h0, "R5 read beyond table");
        stream(0, N + 3, 1'b0, "R1 unprogrammed");

        // R2 program with garbage reserved bits; R4 stride
        for (int j = 0; j < N; j++)
            cfg_write(3'd5, j, {16'hDEAD, v1(j), 16'hBEEF, v0(j)});
        for (int j = 0; j < N; j++)
            cfg_read(3'd5, j, {16'h0, v1(j), 16'h0, v0(j)}, "R2 R4 readback");

        // R4 foreign select: write ignored, read leaves data alone
        cfg_write(3'd4, 2, 64'h0000_7777_0000_7777);
        cfg_read(3'd5, 2, {16'h0, v1(2), 16'h0, v0(2)}, "R4 foreign write ignored");
        cfg_read(3'd1, 0, {16'h0, v1(2), 16'h0, v0(2)}, "R4 foreign read ignored");
        // R5 write beyond table (would alias entry 0 if not range checked)
        cfg_write(3'd5, N, 64'h0000_6666_0000_6666);
        cfg_read(3'd5, 0, {16'h0, v1(0), 16'h0, v0(0)}, "R5 write beyond table ignored");

        // R3 R5 R7 programmed stream, in order at one per cycle
        stream(0, N + 3, 1'b1, "R3 R5 R7 stream");

        // R6 R9 entry 0 both enabled, port 1 not ready
        @(negedge clk);
        in_valid = 1'b1; in_idx = 16'd0; out0_ready = 1'b1; out1_ready = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R6 stall valid0", 64'(out0_valid), 64'(0));
        chk("R6 stall valid1", 64'(out1_valid), 64'(1));
        chk("R6 stall in_ready", 64'(in_ready), 64'(0));
        @(negedge clk);
        chk("R9 stable idx1", 64'(out1_idx), 64'(v1(0)));
        chk("R6 still stalled", 64'(in_ready), 64'(0));
        out1_ready = 1'b1;
        #1;
        chk("R6 both offered", 64'(out0_valid && out1_valid), 64'(1));
        @(negedge clk);
        chk("R6 released", 64'({out0_valid, out1_valid, in_ready}), 64'(3'b001));

        // R6 disabled port 0 (entry 3) ready low does not stall
        out0_ready = 1'b0; out1_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b1; in_idx = 16'd3;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R6 disabled port ignored", 64'({out0_valid, out1_valid, in_ready}), 64'(3'b011));
        @(negedge clk);
        chk("R6 disabled port released", 64'({out0_valid, out1_valid}), 64'(2'b00));
        out0_ready = 1'b1;

        // R8 same-cycle write and lookup of entry 5
        @(negedge clk);
        cfg_sel = 3'd5; cfg_addr = 16'(5 * 32); cfg_wr = 1'b1;
        cfg_wdata = 64'h0000_4321_0000_1234;
        in_valid = 1'b1; in_idx = 16'd5;
        @(negedge clk);
        cfg_wr = 1'b0; in_valid = 1'b0;
        chk("R8 old idx0", 64'(out0_idx), 64'(v0(5)));
        chk("R8 old idx1", 64'(out1_idx), 64'(v1(5)));
        @(negedge clk);
        in_valid = 1'b1; in_idx = 16'd5;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R8 new idx0", 64'(out0_idx), 64'h1234);
        chk("R8 new idx1", 64'(out1_idx), 64'h4321);
        @(negedge clk);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule